// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Banked Masks

This block collects up to 96 level-sensitive interrupt sources and turns them into two processor request lines, a normal request and a fast request. The sources are grouped into banks of 32. Each bank can be read as a raw view or as a per-route pending view. Each bank has a mask that software changes only through separate set and clear write ports. Each bank also has software-interrupt set and clear ports. Every source has its own line register. That register holds a 6-bit priority and a route bit that sends the source to the normal or the fast channel.

For each channel, a selector picks the eligible source with the smallest priority value. On a tie, the lowest source number wins. The channel freezes that number in its active-number register and asserts its request output. The number stays frozen until software writes the matching agreement bit in the control register. Only after that write does the channel sample a new winner. A priority threshold can hold back low-urgency sources. A soft-reset command returns the whole block to its power-up state and reports completion through a status bit. The bus is a plain 32-bit register port with a single-cycle write strobe and a combinational read path.

Top module: `intc_top`

## Requirements
- R1: After reset every mask bit reads 1, every line register reads 0, the threshold at 0x68 reads 0xFF, the status bit 0 at 0x14 reads 1, and `irq_o` and `fiq_o` are low.
- R2: Bank b sits at byte 0x80 + 0x20*b. Source n is bank n/32, bit n%32. Writing 1s to word +0x0C sets mask bits, and writing 1s to word +0x08 clears them. Zero bits leave the mask unchanged. Word +0x04 reads the mask, and 1 means blocked.
- R3: Word +0x00 of a bank reads the raw pending bits (input OR software bit) regardless of mask. Word +0x18 reads pending bits that are unmasked and routed to the normal channel. Word +0x1C reads pending bits that are unmasked and routed to the fast channel.
- R4: Writing 1s to word +0x10 of a bank sets software-pending bits. Writing 1s to word +0x14 clears them. Zero bits have no effect.
- R5: Among eligible sources, a smaller priority value wins. Among equal priorities, the lower source number wins.
- R6: The active-normal register at 0x40 returns the captured winner in bits [6:0]. While `irq_o` is high, that number does not change, even when a more urgent source becomes eligible.
- R7: Writing 1 to bit 0 of the control register at 0x48 drops `irq_o` in the following cycle. One cycle later the channel captures the current best eligible source.
- R8: Bit 0 of a line register set to 1 routes the source to the fast channel. That channel drives `fiq_o`, reports its winner at 0x44, and is released by writing bit 1 of 0x48.
- R9: When the threshold is not 0xFF, a source whose priority is greater than or equal to the threshold is not eligible.
- R10: Writing bit 1 of 0x10 starts a soft reset. Status bit 0 at 0x14 reads 0 for one cycle. After that the block is back in its R1 state and the status bit reads 1.
- R11: The line register for source n is at 0x100 + 4*n. Bits [7:2] hold the priority and bit 0 holds the route. Bit 1 and bits [31:8] read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| src_i | input | 96 | Level interrupt inputs, one per source |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal-channel request, high while a winner is held |
| fiq_o | output | 1 | Fast-channel request, high while a winner is held |

## Verification
On every cycle, the assertions check three things. A held normal-channel number never moves before an agreement write or a soft reset. An agreement write drops the matching request on the next cycle. A soft reset leaves all masks set with both requests low, and shows the busy status in the cycle after the command. Other behaviours need the bench's scenarios: which source wins a priority or number tie, the threshold cut-off, the correct bits in the raw and per-route pending views, and the mask ports leaving zero bits alone. Each of these depends on values chosen across several register writes.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned PRIO_W      = 6;
  localparam int unsigned OFS_CFG     = 32'h10;
  localparam int unsigned OFS_STAT    = 32'h14;
  localparam int unsigned OFS_ACT_IRQ = 32'h40;
  localparam int unsigned OFS_ACT_FIQ = 32'h44;
  localparam int unsigned OFS_CTRL    = 32'h48;
  localparam int unsigned OFS_THR     = 32'h68;
  localparam int unsigned OFS_BANK    = 32'h80;
  localparam int unsigned BANK_STRIDE = 32'h20;
  localparam int unsigned OFS_LINE    = 32'h100;
  localparam logic [7:0]  THR_OFF     = 8'hFF;

  // bank word selectors (address bits [4:2] inside a bank)
  localparam logic [2:0] BW_RAW  = 3'd0;
  localparam logic [2:0] BW_MASK = 3'd1;
  localparam logic [2:0] BW_MCLR = 3'd2;
  localparam logic [2:0] BW_MSET = 3'd3;
  localparam logic [2:0] BW_SSET = 3'd4;
  localparam logic [2:0] BW_SCLR = 3'd5;
  localparam logic [2:0] BW_PIRQ = 3'd6;
  localparam logic [2:0] BW_PFIQ = 3'd7;

  // a source passes the threshold when filtering is off or it is more urgent
  function automatic logic thr_pass(input logic [PRIO_W-1:0] prio, input logic [7:0] thr);
    return (thr == THR_OFF) || ({{(8-PRIO_W){1'b0}}, prio} < thr);
  endfunction

  // strict comparison: on equal priority the earlier (lower) index is kept
  function automatic logic prio_beats(input logic [PRIO_W-1:0] cand, input logic [PRIO_W-1:0] best);
    return cand < best;
  endfunction
endpackage

// File: rtl/intc_pick.sv
module intc_pick
  import intc_pkg::*;
#(
  parameter int N  = 96,
  parameter int IW = 7
) (
  input  logic [N-1:0]              elig_i,
  input  logic [N-1:0][PRIO_W-1:0]  prio_i,
  output logic                      found_o,
  output logic [IW-1:0]             id_o
);
  logic              found_v;
  logic [IW-1:0]     id_v;
  logic [PRIO_W-1:0] best_v;

  always_comb begin
    found_v = 1'b0;
    id_v    = '0;
    best_v  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!found_v || prio_beats(prio_i[i], best_v))) begin
        found_v = 1'b1;
        id_v    = IW'(i);
        best_v  = prio_i[i];
      end
    end
  end

  assign found_o = found_v;
  assign id_o    = id_v;
endmodule

// File: rtl/intc_hold.sv
module intc_hold #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rel_i,
  input  logic          found_i,
  input  logic [IW-1:0] win_i,
  output logic          valid_o,
  output logic [IW-1:0] id_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      valid_o <= 1'b0;
      id_o    <= '0;
    end else if (rel_i) begin
      valid_o <= 1'b0;
      id_o    <= '0;
    end else if (!valid_o && found_i) begin
      valid_o <= 1'b1;
      id_o    <= win_i;
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int BANKS = (NUM_SRC + 31) / 32;
  localparam int NP    = BANKS * 32;
  localparam int IW    = $clog2(NUM_SRC);

  logic [NP-1:0]                   mask_q, sw_q, raw_w, route_w;
  logic [NUM_SRC-1:0]              route_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [7:0]                      thr_q;
  logic                            soft_q;

  // address decode
  logic [31:0] addr32, bank_off, line_off, bank_sel, line_idx;
  logic [2:0]  bank_word;
  logic        bank_hit, line_hit;
  assign addr32    = 32'(bus_addr);
  assign bank_off  = addr32 - OFS_BANK;
  assign line_off  = addr32 - OFS_LINE;
  assign bank_sel  = bank_off >> 5;
  assign bank_word = bank_off[4:2];
  assign line_idx  = line_off >> 2;
  assign bank_hit  = (addr32 >= OFS_BANK) && (addr32 < OFS_BANK + BANK_STRIDE * BANKS);
  assign line_hit  = (addr32 >= OFS_LINE) && (addr32 < OFS_LINE + 4 * NUM_SRC);

  // named events for the checker
  logic [1:0] rel_w;
  logic       rel_irq_w, rel_fiq_w, soft_w, done_w;
  logic [NP-1:0] mask_w;
  assign rel_w[0]  = bus_we && (addr32 == OFS_CTRL) && bus_wdata[0];
  assign rel_w[1]  = bus_we && (addr32 == OFS_CTRL) && bus_wdata[1];
  assign rel_irq_w = rel_w[0];
  assign rel_fiq_w = rel_w[1];
  assign soft_w    = soft_q;
  assign done_w    = ~soft_q;
  assign mask_w    = mask_q;

  // register state
  always_ff @(posedge clk) begin
    if (!rst_n || soft_q) begin
      mask_q  <= '1;
      sw_q    <= '0;
      route_q <= '0;
      prio_q  <= '0;
      thr_q   <= THR_OFF;
      soft_q  <= 1'b0;
    end else if (bus_we) begin
      if (addr32 == OFS_CFG) soft_q <= bus_wdata[1];
      if (addr32 == OFS_THR) thr_q  <= bus_wdata[7:0];
      for (int b = 0; b < BANKS; b++) begin
        if (bank_hit && bank_sel == 32'(b)) begin
          case (bank_word)
            BW_MCLR: mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] & ~bus_wdata;
            BW_MSET: mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] |  bus_wdata;
            BW_SSET: sw_q[b*32 +: 32]   <= sw_q[b*32 +: 32]   |  bus_wdata;
            BW_SCLR: sw_q[b*32 +: 32]   <= sw_q[b*32 +: 32]   & ~bus_wdata;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < NUM_SRC; i++) begin
        if (line_hit && line_idx == 32'(i)) begin
          prio_q[i]  <= bus_wdata[7:2];
          route_q[i] <= bus_wdata[0];
        end
      end
    end
  end

  // eligibility per channel (0 = normal, 1 = fast)
  assign raw_w   = NP'(src_i) | sw_q;
  assign route_w = NP'(route_q);
  logic [1:0][NUM_SRC-1:0] elig_w;
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      elig_w[0][i] = raw_w[i] & ~mask_q[i] & thr_pass(prio_q[i], thr_q) & ~route_q[i];
      elig_w[1][i] = raw_w[i] & ~mask_q[i] & thr_pass(prio_q[i], thr_q) &  route_q[i];
    end
  end

  logic [1:0]         found_w, held_w;
  logic [1:0][IW-1:0] win_w, hid_w;
  for (genvar c = 0; c < 2; c++) begin : g_chan
    intc_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
      .elig_i (elig_w[c]),
      .prio_i (prio_q),
      .found_o(found_w[c]),
      .id_o   (win_w[c])
    );
    intc_hold #(.IW(IW)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (soft_q),
      .rel_i  (rel_w[c]),
      .found_i(found_w[c]),
      .win_i  (win_w[c]),
      .valid_o(held_w[c]),
      .id_o   (hid_w[c])
    );
  end

  logic [IW-1:0] irq_id_w;
  assign irq_id_w = hid_w[0];
  assign irq_o    = held_w[0];
  assign fiq_o    = held_w[1];

  // read path
  always_comb begin
    bus_rdata = '0;
    if (addr32 == OFS_STAT) begin
      bus_rdata[0] = done_w;
    end else if (addr32 == OFS_ACT_IRQ) begin
      bus_rdata[IW-1:0] = hid_w[0];
    end else if (addr32 == OFS_ACT_FIQ) begin
      bus_rdata[IW-1:0] = hid_w[1];
    end else if (addr32 == OFS_THR) begin
      bus_rdata[7:0] = thr_q;
    end else if (bank_hit) begin
      for (int b = 0; b < BANKS; b++) begin
        if (bank_sel == 32'(b)) begin
          case (bank_word)
            BW_RAW:  bus_rdata = raw_w[b*32 +: 32];
            BW_MASK: bus_rdata = mask_q[b*32 +: 32];
            BW_PIRQ: bus_rdata = raw_w[b*32 +: 32] & ~mask_q[b*32 +: 32] & ~route_w[b*32 +: 32];
            BW_PFIQ: bus_rdata = raw_w[b*32 +: 32] & ~mask_q[b*32 +: 32] &  route_w[b*32 +: 32];
            default: bus_rdata = '0;
          endcase
        end
      end
    end else if (line_hit) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (line_idx == 32'(i)) begin
          bus_rdata[7:2] = prio_q[i];
          bus_rdata[0]   = route_q[i];
        end
      end
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 96,
  parameter int ADDR_W  = 10,
  parameter int IW      = 7,
  parameter int NP      = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [IW-1:0]     irq_id_w,
  input logic              rel_irq_w,
  input logic              rel_fiq_w,
  input logic              soft_w,
  input logic              done_w,
  input logic [NP-1:0]     mask_w
);
  logic cfg_soft_wr;
  assign cfg_soft_wr = bus_we && (bus_addr == ADDR_W'(32'h10)) && bus_wdata[1];

  // R6: a held number does not move before release or soft reset
  p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rel_irq_w && !soft_w) |=> $stable(irq_id_w));

  // R6: a held number is a real source index
  p_id_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (32'(irq_id_w) < 32'(NUM_SRC)));

  // R7: agreement on the normal channel drops its request
  p_release_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_irq_w |=> !irq_o);

  // R8: agreement on the fast channel drops its request
  p_release_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fiq_w |=> !fiq_o);

  // R10: soft reset leaves everything masked and quiet
  p_soft_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_w |=> ((&mask_w) && !irq_o && !fiq_o && done_w));

  // R10: status shows busy right after the command
  p_soft_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_soft_wr |=> !done_w);
endmodule

bind intc_top intc_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IW(IW), .NP(NP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .irq_id_w (irq_id_w),
  .rel_irq_w(rel_irq_w),
  .rel_fiq_w(rel_fiq_w),
  .soft_w   (soft_w),
  .done_w   (done_w),
  .mask_w   (mask_w)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
  localparam int N = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  intc_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic [6:0] a;  logic [5:0] pa;
    logic [6:0] b;  logic [5:0] pb;
    logic [6:0] win;
  } vec_t;

  // R5 table: two sources, their priorities, expected winner
  localparam vec_t VECS [5] = '{
    '{7'd5,  6'd3,  7'd70, 6'd1,  7'd70},
    '{7'd10, 6'd2,  7'd3,  6'd2,  7'd3},
    '{7'd40, 6'd0,  7'd95, 6'd0,  7'd40},
    '{7'd64, 6'd63, 7'd1,  6'd62, 7'd1},
    '{7'd31, 6'd7,  7'd32, 6'd7,  7'd31}
  };

  function automatic logic [31:0] bank_addr(input int n, input int k);
    return 32'h80 + 32'h20 * (n / 32) + 4 * k;
  endfunction
  function automatic logic [31:0] bit_of(input int n);
    return 32'd1 << (n % 32);
  endfunction
  function automatic logic [31:0] line_addr(input int n);
    return 32'h100 + 4 * n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a[9:0]; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a[9:0];
    #2 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic soft_reset();
    wr(32'h10, 32'h2);
    @(posedge clk); #1;
  endtask

  task automatic arm(input int n, input int prio, input int fiq);
    wr(line_addr(n), 32'((prio << 2) | fiq));
    wr(bank_addr(n, 4), bit_of(n));
    wr(bank_addr(n, 2), bit_of(n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 fiq_o", 32'(fiq_o), 0);
    rd(bank_addr(0, 1), d);  check("R1 mask bank0", d, 32'hFFFF_FFFF);
    rd(bank_addr(64, 1), d); check("R1 mask bank2", d, 32'hFFFF_FFFF);
    rd(32'h68, d);           check("R1 threshold", d, 32'hFF);
    rd(line_addr(50), d);    check("R1 line 50", d, 0);
    rd(32'h14, d);           check("R1 status", d, 1);

    // R2 mask set/clear ports
    wr(bank_addr(32, 2), 32'h0000_00F0);
    rd(bank_addr(32, 1), d); check("R2 mask clear", d, 32'hFFFF_FF0F);
    wr(bank_addr(32, 3), 32'h0000_0010);
    rd(bank_addr(32, 1), d); check("R2 mask set", d, 32'hFFFF_FF1F);
    wr(bank_addr(32, 2), 32'h0);
    wr(bank_addr(32, 3), 32'h0);
    rd(bank_addr(32, 1), d); check("R2 zero write no effect", d, 32'hFFFF_FF1F);

    // R3 / R4 raw and pending views, software bits
    soft_reset();
    src_i[33] = 1'b1;
    rd(bank_addr(32, 0), d); check("R3 raw ignores mask", d, 32'h2);
    rd(bank_addr(32, 6), d); check("R3 pend irq masked", d, 0);
    wr(bank_addr(4, 4), bit_of(4));
    rd(bank_addr(4, 0), d);  check("R4 soft set", d, 32'h10);
    wr(bank_addr(4, 5), 32'h0);
    rd(bank_addr(4, 0), d);  check("R4 soft clear zero no effect", d, 32'h10);
    wr(bank_addr(4, 5), bit_of(4));
    rd(bank_addr(4, 0), d);  check("R4 soft clear", d, 0);
    wr(bank_addr(33, 2), bit_of(33));
    rd(bank_addr(32, 6), d); check("R3 pend irq unmasked", d, 32'h2);
    rd(bank_addr(32, 7), d); check("R3 pend fiq", d, 0);
    src_i[33] = 1'b0;

    // R5 priority table
    foreach (VECS[v]) begin
      soft_reset();
      wr(32'h68, 32'h0);
      arm(int'(VECS[v].a), int'(VECS[v].pa), 0);
      arm(int'(VECS[v].b), int'(VECS[v].pb), 0);
      wr(32'h68, 32'hFF);
      settle();
      check("R5 irq_o", 32'(irq_o), 1);
      rd(32'h40, d); check("R5 winner", d, 32'(VECS[v].win));
    end

    // R6 / R7 hold and release
    soft_reset();
    arm(20, 5, 0);
    settle();
    rd(32'h40, d); check("R6 first winner", d, 20);
    arm(7, 1, 0);
    settle();
    rd(32'h40, d); check("R6 frozen", d, 20);
    wr(32'h48, 32'h1);
    check("R7 drop after release", 32'(irq_o), 0);
    @(posedge clk); #1;
    check("R7 recapture", 32'(irq_o), 1);
    rd(32'h40, d); check("R7 new winner", d, 7);

    // R8 fast route
    arm(60, 0, 1);
    settle();
    check("R8 fiq_o", 32'(fiq_o), 1);
    rd(32'h44, d); check("R8 fast winner", d, 60);
    rd(bank_addr(60, 7), d); check("R8 pend fiq view", d, 32'h1000_0000);
    rd(bank_addr(60, 6), d); check("R8 pend irq view", d, 0);
    rd(32'h40, d); check("R8 normal unaffected", d, 7);
    wr(bank_addr(60, 5), bit_of(60));
    wr(32'h48, 32'h2);
    check("R8 fast release", 32'(fiq_o), 0);
    settle();
    check("R8 fast stays low", 32'(fiq_o), 0);
    check("R8 normal still held", 32'(irq_o), 1);

    // R9 threshold
    soft_reset();
    wr(32'h68, 32'h4);
    arm(3, 4, 0);
    settle();
    check("R9 blocked at threshold", 32'(irq_o), 0);
    wr(32'h68, 32'h5);
    settle();
    check("R9 passes below threshold", 32'(irq_o), 1);
    rd(32'h40, d); check("R9 winner", d, 3);

    // R11 line layout
    wr(line_addr(77), 32'hFFFF_FFFF);
    rd(line_addr(77), d); check("R11 line readback", d, 32'hFD);

    // R10 soft reset
    wr(32'h10, 32'h2);
    rd(32'h14, d); check("R10 busy", d, 0);
    @(posedge clk); #1;
    rd(32'h14, d); check("R10 done", d, 1);
    check("R10 irq low", 32'(irq_o), 0);
    rd(bank_addr(0, 1), d); check("R10 masks", d, 32'hFFFF_FFFF);
    rd(line_addr(3), d);    check("R10 line cleared", d, 0);
    rd(32'h68, d);          check("R10 threshold", d, 32'hFF);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule